// File: doc/BRIEF.md
# Line-Buffer Scaling Sequencer

This block generates the five control strobes for a line-buffer memory whose write and read pointers advance only while their enables are high. These are write enable, read enable, write-pointer reset, read-pointer reset and output enable. It lowers the rate or the resolution of a video stream by choosing, word by word and line by line, which samples are stored and which are fetched. It never touches the pixel values. A pulse on `line_start_i` marks each new line. The sequencer then counts the words of that line and advances a line phase counter modulo the reduction factor.

Five modes are supported. Pass-through keeps everything. Horizontal decimation keeps one word in n. Line extraction keeps one line in n. Block reduction keeps one word in n on one line in n. Mosaic stores like block reduction but re-reads the stored line on every line, so the output line rate is unchanged. The mode, the factor n and the line length are captured at each line start and hold for that line.

The line controller is a state machine with three states. `ST_IDLE` is the state after reset, before any line has begun. `ST_ACTIVE` covers the active words of a line. `ST_BLANK` follows the last active word. The transitions are:
- start: IDLE→ACTIVE on a line-start pulse.
- finish: ACTIVE→BLANK after the last word.
- restart: ACTIVE→ACTIVE on a line-start pulse in the middle of a line.
- next line: BLANK→ACTIVE on a line-start pulse.

Top module: `lbs_scaler_seq`

## Requirements
- R1: While reset is asserted, and afterwards until the first line-start pulse, write enable, read enable and both pointer-reset strobes are low and output enable is high.
- R2: A line-start pulse sampled at a clock edge makes word 0 of a new line current in the next cycle. The line then spans L cycles, where L is the sampled length (a length of 0 counts as 1), after which all four strobes stay low until the next pulse. A pulse that arrives during a line restarts at word 0.
- R3: Mode code 0 (pass-through), and the unused codes 5, 6 and 7, write and read every word of every line.
- R4: Mode code 1 (horizontal decimation) writes and reads only the words whose index modulo n is 0, on every line.
- R5: Mode code 2 (line extraction) writes and reads every word of lines whose line phase is 0. It neither writes nor reads on the other lines, and output enable is low for the whole of those lines.
- R6: Mode code 3 (block reduction) writes and reads only words whose index modulo n is 0, and only on lines whose line phase is 0. Output enable is low on the other lines.
- R7: Mode code 4 (mosaic) writes the words whose index modulo n is 0 only on lines of phase 0. It reads those same word positions on every line and keeps output enable high.
- R8: The write-pointer reset is high in the word-0 cycle of each line that is written. The read-pointer reset is high in the word-0 cycle of each line that is read. Neither is high at any other time.
- R9: The line phase is 0 on the first line after reset. Each later line-start adds one, and the phase returns to 0 when the result is not below n. A factor input of 0 counts as 1, and n = 1 keeps every word and every line.
- R10: Changes to mode, factor or length between line-start pulses do not affect the current line.
- R11: Read enable is never high while output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle pulse marking the start of a line |
| mode_i | input | 3 | Scaling mode code (0 pass, 1 horizontal, 2 line, 3 block, 4 mosaic) |
| factor_i | input | NF_W | Reduction factor n, 1 to 7 (0 counts as 1) |
| len_i | input | PIX_W | Number of active words in the line |
| wr_en_o | output | 1 | Store the current word and advance the write pointer |
| rd_en_o | output | 1 | Fetch the current word and advance the read pointer |
| rst_wr_o | output | 1 | Return the write pointer to word 0 |
| rst_rd_o | output | 1 | Return the read pointer to word 0 |
| out_en_o | output | 1 | Drive read data onto the output |

## Verification
On every cycle the assertions check the following:
- A line-start pulse always lands on word 0 in the active state.
- The word counter advances by exactly one inside a line.
- Both phase counters stay below the latched factor.
- Each pointer-reset strobe lasts one cycle and coincides with its enable.
- A read never happens while the output is disabled.

These checks cannot tell whether the right words and lines are kept for a given mode and factor. That needs the bench. It sweeps every mode code against every factor over several lines and compares every strobe with a word-by-word and line-by-line prediction. It also covers a line cut short by an early pulse and inputs changed in the middle of a line.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    typedef enum logic [2:0] {
        SM_PASS   = 3'd0,
        SM_HDEC   = 3'd1,
        SM_VDEC   = 3'd2,
        SM_BLOCK  = 3'd3,
        SM_MOSAIC = 3'd4
    } scale_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_BLANK  = 2'd2
    } line_state_e;

    // Per-line decision, fixed at the line start
    typedef struct packed {
        logic wr_line;   // this line is stored
        logic rd_line;   // this line is fetched
        logic hide;      // output disabled for this line
        logic hdec;      // keep only one word in n
    } line_plan_t;

    function automatic scale_mode_e decode_mode(input logic [2:0] code);
        scale_mode_e m;
        unique case (code)
            3'd1:    m = SM_HDEC;
            3'd2:    m = SM_VDEC;
            3'd3:    m = SM_BLOCK;
            3'd4:    m = SM_MOSAIC;
            default: m = SM_PASS;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lbs_line_tracker.sv
module lbs_line_tracker
    import lbs_pkg::*;
#(
    parameter int NF_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_start_i,
    input  logic [2:0]      mode_i,
    input  logic [NF_W-1:0] factor_i,
    output logic [NF_W-1:0] n_o,
    output logic [NF_W-1:0] phase_o,
    output line_plan_t      plan_o
);

    localparam logic [NF_W-1:0] N_ONE  = NF_W'(1);
    localparam logic [NF_W:0]   ONE_XW = (NF_W+1)'(1);

    logic            seen_q;
    logic [NF_W-1:0] phase_q, phase_nxt;
    logic [NF_W-1:0] n_q, n_eff;
    line_plan_t      plan_q, plan_nxt;
    logic            keep_line;
    scale_mode_e     mode_dec;

    assign n_eff    = (factor_i == '0) ? N_ONE : factor_i;
    assign mode_dec = decode_mode(mode_i);

    always_comb begin
        if (!seen_q) begin
            phase_nxt = '0;
        end else if (({1'b0, phase_q} + ONE_XW) >= {1'b0, n_eff}) begin
            phase_nxt = '0;
        end else begin
            phase_nxt = phase_q + N_ONE;
        end
    end

    assign keep_line = (phase_nxt == '0);

    always_comb begin
        plan_nxt = '{wr_line: 1'b1, rd_line: 1'b1, hide: 1'b0, hdec: 1'b0};
        unique case (mode_dec)
            SM_PASS: ;
            SM_HDEC: plan_nxt.hdec = 1'b1;
            SM_VDEC: begin
                plan_nxt.wr_line = keep_line;
                plan_nxt.rd_line = keep_line;
                plan_nxt.hide    = !keep_line;
            end
            SM_BLOCK: begin
                plan_nxt.wr_line = keep_line;
                plan_nxt.rd_line = keep_line;
                plan_nxt.hide    = !keep_line;
                plan_nxt.hdec    = 1'b1;
            end
            SM_MOSAIC: begin
                plan_nxt.wr_line = keep_line;
                plan_nxt.hdec    = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            phase_q <= '0;
            n_q     <= N_ONE;
            plan_q  <= '{wr_line: 1'b0, rd_line: 1'b0, hide: 1'b0, hdec: 1'b0};
        end else if (line_start_i) begin
            seen_q  <= 1'b1;
            phase_q <= phase_nxt;
            n_q     <= n_eff;
            plan_q  <= plan_nxt;
        end
    end

    assign n_o     = n_q;
    assign phase_o = phase_q;
    assign plan_o  = plan_q;

    // R9
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < n_q);

    // R9
    factor_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        n_q != '0);

    // R10
    plan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start_i |=> $stable(plan_q) && $stable(n_q));

endmodule

// File: rtl/lbs_pixel_fsm.sv
module lbs_pixel_fsm
    import lbs_pkg::*;
#(
    parameter int PIX_W = 13,
    parameter int NF_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start_i,
    input  logic [PIX_W-1:0] len_i,
    input  logic [NF_W-1:0]  n_i,
    output line_state_e      state_o,
    output logic [PIX_W-1:0] pix_o,
    output logic [NF_W-1:0]  hphase_o
);

    localparam logic [PIX_W:0]   ONE_XP = (PIX_W+1)'(1);
    localparam logic [PIX_W-1:0] P_ONE  = PIX_W'(1);
    localparam logic [NF_W:0]    ONE_XF = (NF_W+1)'(1);
    localparam logic [NF_W-1:0]  F_ONE  = NF_W'(1);

    line_state_e      state_q, state_nxt;
    logic [PIX_W-1:0] pix_q, len_q;
    logic [NF_W-1:0]  hph_q;
    logic             last_word;

    assign last_word = ({1'b0, pix_q} + ONE_XP) >= {1'b0, len_q};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:   if (line_start_i) state_nxt = ST_ACTIVE;
            ST_ACTIVE: begin
                if (line_start_i)   state_nxt = ST_ACTIVE;
                else if (last_word) state_nxt = ST_BLANK;
                else                state_nxt = ST_ACTIVE;
            end
            ST_BLANK:  if (line_start_i) state_nxt = ST_ACTIVE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Word and horizontal phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
            hph_q <= '0;
            len_q <= P_ONE;
        end else if (line_start_i) begin
            pix_q <= '0;
            hph_q <= '0;
            len_q <= len_i;
        end else if (state_q == ST_ACTIVE && !last_word) begin
            pix_q <= pix_q + P_ONE;
            if (({1'b0, hph_q} + ONE_XF) >= {1'b0, n_i}) begin
                hph_q <= '0;
            end else begin
                hph_q <= hph_q + F_ONE;
            end
        end
    end

    // Outputs
    always_comb begin
        state_o  = state_q;
        pix_o    = pix_q;
        hphase_o = hph_q;
    end

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_i |=> (state_q == ST_ACTIVE) && (pix_q == '0) && (hph_q == '0));

    // R2
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !line_start_i && !last_word)
            |=> pix_q == $past(pix_q) + P_ONE);

    // R2
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLANK && !line_start_i) |=> state_q == ST_BLANK);

    // R4
    hphase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hph_q < n_i);

endmodule

// File: rtl/lbs_strobe_gen.sv
module lbs_strobe_gen
    import lbs_pkg::*;
#(
    parameter int PIX_W = 13,
    parameter int NF_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start_i,
    input  line_state_e      state_i,
    input  logic [PIX_W-1:0] pix_i,
    input  logic [NF_W-1:0]  hphase_i,
    input  line_plan_t       plan_i,
    output logic             wr_en_o,
    output logic             rd_en_o,
    output logic             rst_wr_o,
    output logic             rst_rd_o,
    output logic             out_en_o
);

    logic active, word_kept, first_word;

    always_comb begin
        active     = (state_i == ST_ACTIVE);
        word_kept  = !plan_i.hdec || (hphase_i == '0);
        first_word = active && (pix_i == '0);
        wr_en_o    = active && plan_i.wr_line && word_kept;
        rd_en_o    = active && plan_i.rd_line && word_kept;
        rst_wr_o   = first_word && plan_i.wr_line;
        rst_rd_o   = first_word && plan_i.rd_line;
        out_en_o   = !plan_i.hide;
    end

    // R8
    rst_wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_wr_o && !line_start_i) |=> !rst_wr_o);

    // R8
    rst_rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_rd_o && !line_start_i) |=> !rst_rd_o);

    // R8
    rst_wr_with_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr_o |-> wr_en_o);

    // R8
    rst_rd_with_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_rd_o |-> rd_en_o);

endmodule

// File: rtl/lbs_scaler_seq.sv
module lbs_scaler_seq
    import lbs_pkg::*;
#(
    parameter int PIX_W = 13,
    parameter int NF_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start_i,
    input  logic [2:0]       mode_i,
    input  logic [NF_W-1:0]  factor_i,
    input  logic [PIX_W-1:0] len_i,
    output logic             wr_en_o,
    output logic             rd_en_o,
    output logic             rst_wr_o,
    output logic             rst_rd_o,
    output logic             out_en_o
);

    logic [NF_W-1:0]  n_cur;
    logic [NF_W-1:0]  vphase;
    line_plan_t       plan;
    line_state_e      state;
    logic [PIX_W-1:0] pix;
    logic [NF_W-1:0]  hphase;

    lbs_line_tracker #(.NF_W(NF_W)) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .mode_i       (mode_i),
        .factor_i     (factor_i),
        .n_o          (n_cur),
        .phase_o      (vphase),
        .plan_o       (plan)
    );

    lbs_pixel_fsm #(.PIX_W(PIX_W), .NF_W(NF_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .len_i        (len_i),
        .n_i          (n_cur),
        .state_o      (state),
        .pix_o        (pix),
        .hphase_o     (hphase)
    );

    lbs_strobe_gen #(.PIX_W(PIX_W), .NF_W(NF_W)) u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .state_i      (state),
        .pix_i        (pix),
        .hphase_i     (hphase),
        .plan_i       (plan),
        .wr_en_o      (wr_en_o),
        .rd_en_o      (rd_en_o),
        .rst_wr_o     (rst_wr_o),
        .rst_rd_o     (rst_rd_o),
        .out_en_o     (out_en_o)
    );

    // R11
    no_read_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_o |-> !rd_en_o);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !wr_en_o && !rd_en_o && out_en_o);

    // R9
    vphase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vphase < n_cur);

endmodule

// File: tb/lbs_scaler_seq_bench.sv
module lbs_scaler_seq_bench;

    localparam int PIX_W = 13;
    localparam int NF_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_start_i = 1'b0;
    logic [2:0]       mode_i = '0;
    logic [NF_W-1:0]  factor_i = NF_W'(1);
    logic [PIX_W-1:0] len_i = PIX_W'(1);
    logic             wr_en_o, rd_en_o, rst_wr_o, rst_rd_o, out_en_o;

    int checks = 0;
    int fails  = 0;

    // Bench model of the line currently in progress
    bit seen = 0;
    int ph = 0;
    int cur_md = 0;
    int cur_n = 1;
    int cur_len = 1;

    always #2 clk = ~clk;   // 250 MHz

    lbs_scaler_seq #(.PIX_W(PIX_W), .NF_W(NF_W)) u_lbs_scaler_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .mode_i       (mode_i),
        .factor_i     (factor_i),
        .len_i        (len_i),
        .wr_en_o      (wr_en_o),
        .rd_en_o      (rd_en_o),
        .rst_wr_o     (rst_wr_o),
        .rst_rd_o     (rst_rd_o),
        .out_en_o     (out_en_o)
    );

    function automatic string mode_req(input int md);
        case (md)
            1:       return "R4";
            2:       return "R5";
            3:       return "R6";
            4:       return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic compare(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // Expected strobes for word k of the current line
    task automatic check_word(input int k, input string tag);
        bit act_w, hkeep, keep, wl, rl, hide, hd;
        logic [2:0] e_main, a_main;
        logic [1:0] e_rst;
        string req;
        act_w = (k < cur_len);
        keep  = (ph == 0);
        hd    = (cur_md == 1 || cur_md == 3 || cur_md == 4);
        hkeep = !hd || ((k % cur_n) == 0);
        wl    = (cur_md == 2 || cur_md == 3 || cur_md == 4) ? keep : 1'b1;
        rl    = (cur_md == 2 || cur_md == 3) ? keep : 1'b1;
        hide  = (cur_md == 2 || cur_md == 3) ? !keep : 1'b0;
        e_main = {act_w && wl && hkeep, act_w && rl && hkeep, !hide};
        e_rst  = {act_w && k == 0 && wl, act_w && k == 0 && rl};
        a_main = {wr_en_o, rd_en_o, out_en_o};
        req = (tag != "") ? tag : (act_w ? mode_req(cur_md) : "R2");
        compare(req, a_main, e_main);
        compare((tag != "") ? tag : "R8", {1'b0, rst_wr_o, rst_rd_o}, {1'b0, e_rst});
        // R11: read enable never with output disabled
        compare("R11", {2'b0, rd_en_o && !out_en_o}, 3'b000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        line_start_i = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset values
        compare("R1", {wr_en_o, rd_en_o, out_en_o}, 3'b001);
        compare("R1", {1'b0, rst_wr_o, rst_rd_o}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", {wr_en_o, rd_en_o, out_en_o}, 3'b001);
        seen = 0;
        ph = 0;
    endtask

    // One line: pulse, then ncyc sampled cycles; inputs scrambled after word chg_at
    task automatic run_line(input int md, input int nf, input int ln, input int ncyc,
                            input int chg_at, input string tag);
        int neff;
        @(negedge clk);
        mode_i = 3'(md);
        factor_i = NF_W'(nf);
        len_i = PIX_W'(ln);
        line_start_i = 1'b1;
        neff = (nf == 0) ? 1 : nf;
        // R9: line phase model
        if (!seen) ph = 0;
        else ph = ((ph + 1) >= neff) ? 0 : ph + 1;
        seen = 1;
        cur_md = md;
        cur_n = neff;
        cur_len = (ln == 0) ? 1 : ln;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            line_start_i = 1'b0;
            check_word(k, tag);
            if (k == chg_at) begin
                // R10: these must not reach the current line
                mode_i = 3'd3;
                factor_i = NF_W'(2);
                len_i = PIX_W'(3);
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        // Sweep every mode code against every factor (R3..R9)
        for (int md = 0; md < 8; md++) begin
            for (int nf = 0; nf < 8; nf++) begin
                int neff;
                neff = (nf == 0) ? 1 : nf;
                do_reset();
                for (int l = 0; l < 2 * neff + 1; l++) begin
                    run_line(md, nf, 9, 12, -1, "");
                end
            end
        end

        // R10: inputs changed mid-line leave the line untouched
        do_reset();
        run_line(4, 3, 10, 13, 3, "R10");
        run_line(2, 3, 7, 10, 2, "R10");
        run_line(0, 1, 6, 9, 1, "R10");

        // R2: early pulse cuts the line, restart at word 0
        do_reset();
        run_line(3, 2, 9, 4, -1, "R2");
        run_line(3, 2, 9, 12, -1, "R2");
        run_line(1, 3, 9, 1, -1, "R2");
        run_line(1, 3, 9, 12, -1, "R2");
        // R2: zero length counts as one word
        run_line(0, 1, 0, 4, -1, "R2");

        // R9: factor change between lines rewraps phase
        do_reset();
        run_line(2, 5, 5, 7, -1, "R9");
        run_line(2, 5, 5, 7, -1, "R9");
        run_line(2, 5, 5, 7, -1, "R9");
        run_line(2, 5, 5, 7, -1, "R9");
        run_line(2, 2, 5, 7, -1, "R9");
        run_line(2, 2, 5, 7, -1, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule